// File: doc/BRIEF.md
# Single-Source Shared Register Bus

Three data registers exchange values over one shared transfer bus. In each clock exactly one register may drive the bus, and any combination of the three may capture the bus value on the next rising edge. A single transfer can therefore copy one register into another, or broadcast one register into the other two. Swapping two registers in one cycle is not possible, because that needs two drivers at once.

Two ways of naming the driver are available, chosen by `modeOneHot`. In binary mode a two-bit code picks the source. In one-hot mode there is one enable per register, which stands in for a tri-state driver. That driver is modelled with AND-OR gating rather than real high-impedance logic. An illegal request raises `busErr` in the same cycle and suppresses every bus load. An illegal request is the unused binary code, or more than one enable in one-hot mode. A direct write port sets the initial register contents, since the bus can only move values that are already held in the registers.

Top module: `shared_reg_bus`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all three registers to zero, whatever the load and write inputs are doing.
- R2: In binary mode (`modeOneHot`=0), `srcSel` code 00 places register 0 on `busOut`, code 01 places register 1 and code 10 places register 2, with `busErr` low.
- R3: In one-hot mode (`modeOneHot`=1), `srcEn` bit k alone set places register k on `busOut`, with `busErr` low.
- R4: At a rising edge, each register whose `loadVec` bit (bit k for register k) is set and no error is flagged takes the value `busOut` had before the edge. A register with a clear load bit and no write keeps its value, and this includes the register that is driving the bus.
- R5: Setting several load bits in one cycle copies the single bus value into all the selected registers in the same edge. For example, source 1 with loads 101 writes register 1 into registers 0 and 2.
- R6: In binary mode, code 11 drives `busOut` to zero and raises `busErr` in the same cycle, and no register loads from the bus at the following edge.
- R7: In one-hot mode, two or more set bits in `srcEn` raise `busErr` with `busOut` zero, and no register loads from the bus at the following edge.
- R8: In one-hot mode, `srcEn`=000 gives `busOut`=0 with `busErr` low, and any selected loads capture zero.
- R9: In binary mode `srcEn` has no effect, and in one-hot mode `srcSel` has no effect. The same source and loads give the same register results in either mode.
- R10: When `wrEn` is high, register `wrIdx` (0 to 2) takes `wrData` at the edge, and index 3 writes nothing. A bus load of the same register in the same cycle takes priority over the write. A bus error suppresses only bus loads and leaves the write in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| modeOneHot | input | 1 | 0: binary source code, 1: one-hot enables |
| srcSel | input | 2 | Binary source code (00 reg0, 01 reg1, 10 reg2, 11 illegal) |
| srcEn | input | 3 | One-hot source enables, bit k for register k |
| loadVec | input | 3 | Destination loads, bit k for register k |
| wrEn | input | 1 | Direct write strobe |
| wrIdx | input | 2 | Direct write target index |
| wrData | input | DataW | Direct write value |
| reg0Out | output | DataW | Register 0 contents |
| reg1Out | output | DataW | Register 1 contents |
| reg2Out | output | DataW | Register 2 contents |
| busOut | output | DataW | Current shared bus value |
| busErr | output | 1 | Illegal source request this cycle |

## Verification
A bus transfer and a direct write can land in the same cycle. The bench provokes this in two ways. First, it loads a register from the bus while also writing that same register, and expects the bus value to win. Second, it pairs a blocked transfer (code 11, or two enables) with a write to a register, and expects only the write to take effect. Each case is judged by a scoreboard that runs a reference model built from the requirements, compared after the edge on all three register outputs.

// File: rtl/shared_reg_bus_pkg.sv
package shared_reg_bus_pkg;
  localparam int NumRegs = 3;
  localparam int SelW    = $clog2(NumRegs + 1);

  typedef struct packed {
    logic [NumRegs-1:0] grant;    // one-hot bus driver
    logic [NumRegs-1:0] busLoad;  // capture bus into register k
    logic [NumRegs-1:0] extLoad;  // capture direct write data into register k
    logic               busErr;   // illegal source request
  } busCtrl_t;
endpackage

// File: rtl/shared_reg_bus_ctrl.sv
module shared_reg_bus_ctrl
  import shared_reg_bus_pkg::*;
(
  input  logic                modeOneHot,
  input  logic [SelW-1:0]     srcSel,
  input  logic [NumRegs-1:0]  srcEn,
  input  logic [NumRegs-1:0]  loadVec,
  input  logic                wrEn,
  input  logic [SelW-1:0]     wrIdx,
  output busCtrl_t            ctrl
);
  logic [NumRegs-1:0] grantSel;
  logic               errSel;

  // source arbitration: decode or validate, never resolve contention
  always_comb begin
    grantSel = '0;
    errSel   = 1'b0;
    if (modeOneHot) begin
      if ($countones(srcEn) > 1) errSel = 1'b1;
      else                       grantSel = srcEn;
    end else begin
      if (int'(srcSel) < NumRegs) grantSel[srcSel] = 1'b1;
      else                        errSel = 1'b1;
    end
  end

  always_comb begin
    ctrl.grant   = grantSel;
    ctrl.busErr  = errSel;
    ctrl.busLoad = errSel ? '0 : loadVec;
    for (int k = 0; k < NumRegs; k++) begin
      ctrl.extLoad[k] = wrEn && (wrIdx == SelW'(k));
    end
  end
endmodule

// File: rtl/shared_reg_bus_dp.sv
module shared_reg_bus_dp
  import shared_reg_bus_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  busCtrl_t         ctrl,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] regQ [NumRegs],
  output logic [DataW-1:0] busVal
);
  // AND-OR model of a tri-state bus
  always_comb begin
    busVal = '0;
    for (int k = 0; k < NumRegs; k++) begin
      busVal = busVal | (regQ[k] & {DataW{ctrl.grant[k]}});
    end
  end

  for (genvar k = 0; k < NumRegs; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                  regQ[k] <= '0;
      else if (ctrl.busLoad[k]) regQ[k] <= busVal;
      else if (ctrl.extLoad[k]) regQ[k] <= wrData;
    end
  end
endmodule

// File: rtl/shared_reg_bus.sv
module shared_reg_bus
  import shared_reg_bus_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeOneHot,
  input  logic [1:0]       srcSel,
  input  logic [2:0]       srcEn,
  input  logic [2:0]       loadVec,
  input  logic             wrEn,
  input  logic [1:0]       wrIdx,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] reg0Out,
  output logic [DataW-1:0] reg1Out,
  output logic [DataW-1:0] reg2Out,
  output logic [DataW-1:0] busOut,
  output logic             busErr
);
  busCtrl_t         ctrl;
  logic [DataW-1:0] regQ [NumRegs];

  shared_reg_bus_ctrl ctrl_i (
    .modeOneHot (modeOneHot),
    .srcSel     (srcSel),
    .srcEn      (srcEn),
    .loadVec    (loadVec),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .ctrl       (ctrl)
  );

  shared_reg_bus_dp #(.DataW(DataW)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .wrData (wrData),
    .regQ   (regQ),
    .busVal (busOut)
  );

  assign reg0Out = regQ[0];
  assign reg1Out = regQ[1];
  assign reg2Out = regQ[2];
  assign busErr  = ctrl.busErr;
endmodule

// File: rtl/shared_reg_bus_chk.sv
module shared_reg_bus_chk #(
  parameter int DataW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             modeOneHot,
  input logic [1:0]       srcSel,
  input logic [2:0]       srcEn,
  input logic [2:0]       loadVec,
  input logic             wrEn,
  input logic [1:0]       wrIdx,
  input logic [DataW-1:0] wrData,
  input logic [DataW-1:0] reg0Out,
  input logic [DataW-1:0] reg1Out,
  input logic [DataW-1:0] reg2Out,
  input logic [DataW-1:0] busOut,
  input logic             busErr
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (reg0Out == '0 && reg1Out == '0 && reg2Out == '0));

  p_bin_src1_r2: assert property (@(posedge clk) disable iff (rst)
    (!modeOneHot && srcSel == 2'b01) |-> (busOut == reg1Out && !busErr));

  p_hot_src2_r3: assert property (@(posedge clk) disable iff (rst)
    (modeOneHot && srcEn == 3'b100) |-> (busOut == reg2Out && !busErr));

  p_load_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (loadVec[2] && !busErr) |=> (reg2Out == $past(busOut)));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!loadVec[0] && !(wrEn && wrIdx == 2'd0)) |=> $stable(reg0Out));

  p_bin_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    (!modeOneHot && srcSel == 2'b11) |-> (busErr && busOut == '0));

  p_err_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (busErr && !wrEn) |=> ($stable(reg0Out) && $stable(reg1Out) && $stable(reg2Out)));

  p_multi_enable_r7: assert property (@(posedge clk) disable iff (rst)
    (modeOneHot && $countones(srcEn) > 1) |-> (busErr && busOut == '0));

  p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (modeOneHot && srcEn == 3'b000) |-> (busOut == '0 && !busErr));

  p_bus_over_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx == 2'd1 && loadVec[1] && !busErr) |=> (reg1Out == $past(busOut)));
endmodule

bind shared_reg_bus shared_reg_bus_chk #(.DataW(DataW)) chk_i (.*);

// File: tb/shared_reg_bus_tb_top.sv
`timescale 1ns/1ps
module shared_reg_bus_tb_top;
  localparam int DataW = 8;

  typedef struct {
    string      tag;
    logic [DataW-1:0] exp0;
    logic [DataW-1:0] exp1;
    logic [DataW-1:0] exp2;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             modeOneHot = 1'b0;
  logic [1:0]       srcSel = 2'b00;
  logic [2:0]       srcEn = 3'b000;
  logic [2:0]       loadVec = 3'b000;
  logic             wrEn = 1'b0;
  logic [1:0]       wrIdx = 2'b00;
  logic [DataW-1:0] wrData = '0;
  logic [DataW-1:0] reg0Out, reg1Out, reg2Out, busOut;
  logic             busErr;

  int checks = 0;
  int failures = 0;
  logic [DataW-1:0] model [3];
  item_t q [$];

  always #5 clk = ~clk;

  shared_reg_bus #(.DataW(DataW)) dut_i (.*);

  task automatic check(input string tag, input logic [DataW-1:0] act, input logic [DataW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, checks bus/error, pushes expected registers
  task automatic op(input logic r, input logic m, input logic [1:0] sel, input logic [2:0] en,
                    input logic [2:0] ld, input logic w, input logic [1:0] idx,
                    input logic [DataW-1:0] d, input string tag);
    logic [DataW-1:0] expBus;
    logic             expErr;
    item_t            it;
    @(negedge clk);
    rst = r; modeOneHot = m; srcSel = sel; srcEn = en; loadVec = ld;
    wrEn = w; wrIdx = idx; wrData = d;
    expBus = '0;
    expErr = 1'b0;
    if (m) begin
      case (en)
        3'b000: expBus = '0;
        3'b001: expBus = model[0];
        3'b010: expBus = model[1];
        3'b100: expBus = model[2];
        default: expErr = 1'b1;
      endcase
    end else begin
      case (sel)
        2'b00: expBus = model[0];
        2'b01: expBus = model[1];
        2'b10: expBus = model[2];
        default: expErr = 1'b1;
      endcase
    end
    #1;
    if (!r) begin
      check({tag, " bus"}, busOut, expBus);
      check({tag, " err"}, {{(DataW-1){1'b0}}, busErr}, {{(DataW-1){1'b0}}, expErr});
    end
    for (int k = 0; k < 3; k++) begin
      if (r)                       model[k] = '0;
      else if (ld[k] && !expErr)   model[k] = expBus;
      else if (w && idx == 2'(k))  model[k] = d;
    end
    it.tag = tag; it.exp0 = model[0]; it.exp1 = model[1]; it.exp2 = model[2];
    q.push_back(it);
  endtask

  // monitor: compares registers after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " reg0"}, reg0Out, it.exp0);
        check({it.tag, " reg1"}, reg1Out, it.exp1);
        check({it.tag, " reg2"}, reg2Out, it.exp2);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 3; k++) model[k] = '0;
    op(1, 0, 2'b00, 3'b000, 3'b000, 0, 0, 8'h00, "R1 reset");
    op(1, 0, 2'b00, 3'b000, 3'b000, 0, 0, 8'h00, "R1 reset hold");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 0, 8'h11, "R10 write r0");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 1, 8'h22, "R10 write r1");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 2, 8'h33, "R10 write r2");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 3, 8'hEE, "R10 index3 no write");
    op(0, 0, 2'b00, 3'b000, 3'b001, 0, 0, 8'h00, "R4 self load r0");
    op(0, 0, 2'b10, 3'b000, 3'b001, 0, 0, 8'h00, "R2 r0<-r2");
    op(0, 0, 2'b01, 3'b000, 3'b101, 0, 0, 8'h00, "R5 broadcast r1 bin");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 0, 8'hA5, "R10 write r0");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 2, 8'h5A, "R10 write r2");
    op(0, 1, 2'b11, 3'b100, 3'b001, 0, 0, 8'h00, "R3 hot r0<-r2");
    op(0, 1, 2'b00, 3'b001, 3'b010, 0, 0, 8'h00, "R3 hot r1<-r0");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 1, 8'h3C, "R10 write r1");
    op(0, 1, 2'b00, 3'b010, 3'b101, 0, 0, 8'h00, "R5 broadcast r1 hot");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 0, 8'h01, "R10 write r0");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 2, 8'h04, "R10 write r2");
    op(0, 1, 2'b00, 3'b011, 3'b111, 0, 0, 8'h00, "R7 two enables");
    op(0, 1, 2'b00, 3'b111, 3'b111, 0, 0, 8'h00, "R7 three enables");
    op(0, 0, 2'b11, 3'b000, 3'b111, 0, 0, 8'h00, "R6 illegal code");
    op(0, 1, 2'b00, 3'b000, 3'b010, 0, 0, 8'h00, "R8 idle bus loads zero");
    op(0, 0, 2'b10, 3'b111, 3'b010, 0, 0, 8'h00, "R9 bin ignores enables");
    op(0, 1, 2'b11, 3'b001, 3'b100, 0, 0, 8'h00, "R9 hot ignores code");
    op(0, 0, 2'b00, 3'b000, 3'b000, 1, 0, 8'h77, "R10 write r0");
    op(0, 0, 2'b00, 3'b000, 3'b100, 1, 2, 8'h99, "R10 bus beats write");
    op(0, 0, 2'b00, 3'b000, 3'b010, 1, 2, 8'h66, "R10 load and write differ");
    op(0, 0, 2'b11, 3'b000, 3'b111, 1, 1, 8'h42, "R10 write survives R6 error");
    op(0, 1, 2'b00, 3'b110, 3'b111, 1, 0, 8'h24, "R10 write survives R7 error");
    op(1, 0, 2'b01, 3'b000, 3'b111, 1, 0, 8'hFF, "R1 reset overrides");
    op(0, 0, 2'b00, 3'b000, 3'b000, 0, 0, 8'h00, "R4 idle hold");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule